// File: doc/BRIEF.md
# Storage-Controller Interrupt Status Aggregator

This block holds the main interrupt status register of a storage bus interface controller. It gathers single-cycle event pulses from the protocol and DMA engines into sticky flags. It also shows two summary bits, each the OR of a subordinate status register, and one live bit that is high while a command runs. From these it drives two active-low interrupt lines. The DMA port mode decides which line, if any, the DMA-complete flag reaches.

Software reads the main register first to find where an interrupt came from. It then services the subordinate registers, and clears the sticky flags by writing back the value it read: a 1 clears. The DMA-complete flag can also be read and cleared through a second register. Both views show the same storage bit.

Top module: `intStatusAgg`

## Requirements
- R1: After reset every flag is 0, both registers read 0x00, and irqMainN and irqPortN are both high.
- R2: The main register is at address 0x20. A pulse on evtCmdDone sets bit 7 and a pulse on evtCmdAbort sets bit 6. Each bit stays set until software writes 1 to it at 0x20. Writing 0 to it leaves it unchanged.
- R3: When a set event and a write-1 clear hit bit 7, bit 6 or bit 1 in the same cycle, the bit stays set.
- R4: Bit 1 (DMA complete) sets on evtDmaDone or on evtDmaStop. It also sets on evtCmdAbort or evtAtnTerm, but only while dmaGoActive is high. Without dmaGoActive, an abort or attention pulse leaves bit 1 clear.
- R5: Bit 0 of the register at address 0x00 shows the same flag as bit 1 at 0x20. Writing 1 to either of those bits clears the flag as seen from both addresses.
- R6: Bit 4 is high while subStatA is nonzero and bit 3 is high while subStatB is nonzero. Both bits follow their inputs with no write needed, and writes to them have no effect.
- R7: Bit 5 (executing) is set by evtCmdStart. It is cleared by evtCmdDone, evtCmdAbort or evtAtnTerm. If a start pulse and an end pulse arrive in the same cycle, the start wins. Writes to bit 5 are ignored, and bit 5 alone never asserts either interrupt.
- R8: Bit 0 (auto-sequence complete) sets on evtSeqEnd when either bit of autoModeEn is 1. With autoModeEn at 00 the pulse does nothing. The bit is cleared by the next evtCmdStart, and writes to it are ignored.
- R9: irqMainN is low exactly when any of bits 7, 6, 4, 3 or 0 is set. Bit 1 does not drive irqMainN in either port mode.
- R10: irqPortN is low exactly when bit 1 is set and portMode is not 00. With portMode at 00, irqPortN stays high.
- R11: Bit 2 of the main register always reads 0. Any other address, and the unused bits at 0x00, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register address for reads and writes |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data (a 1 clears a sticky bit) |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| evtCmdStart | input | 1 | Command started pulse |
| evtCmdDone | input | 1 | Command ended normally pulse |
| evtCmdAbort | input | 1 | Command aborted pulse |
| evtAtnTerm | input | 1 | Command ended by attention pulse |
| evtSeqEnd | input | 1 | Specified command of an auto sequence ended |
| autoModeEn | input | 2 | Auto-mode enable bits |
| evtDmaDone | input | 1 | DMA transfer finished pulse |
| evtDmaStop | input | 1 | Software forced DMA termination pulse |
| dmaGoActive | input | 1 | DMA-go control bit is set |
| portMode | input | 2 | DMA port mode |
| subStatA | input | 8 | First subordinate status register contents |
| subStatB | input | 8 | Second subordinate status register contents |
| irqMainN | output | 1 | Main interrupt, active low |
| irqPortN | output | 1 | Port DMA interrupt, active low |

## Verification
A wrong sticky flag shows on regRdData, and on one of the interrupt lines, at the first read after the clock edge that stored it. A lost set or a missing clear is therefore visible one cycle after the event or the write. A mis-routed DMA-complete shows at once as the wrong interrupt line low for the current portMode. A mirror that does not share storage shows as different values at 0x00 and 0x20 right after a clear through only one of them.

// File: rtl/intStatPkg.sv
package intStatPkg;
  localparam int BIT_GOOD  = 7;
  localparam int BIT_ABORT = 6;
  localparam int BIT_EXEC  = 5;
  localparam int BIT_SUM1  = 4;
  localparam int BIT_SUM2  = 3;
  localparam int BIT_DMA   = 1;
  localparam int BIT_ASEQ  = 0;

  typedef struct packed {
    logic selMain;
    logic selPort;
    logic clrGood;
    logic clrAbort;
    logic clrDma;
  } statStrobeT;
endpackage

// File: rtl/intStatCtrl.sv
module intStatCtrl
  import intStatPkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int MAIN_ADDR    = 'h20,
  parameter int PORT_ADDR    = 'h00,
  parameter int PORT_CMP_BIT = 0
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output statStrobeT        strb
);
  localparam logic [ADDR_W-1:0] MAIN_A = ADDR_W'(MAIN_ADDR);
  localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT_ADDR);

  always_comb begin
    strb.selMain  = (regAddr == MAIN_A);
    strb.selPort  = (regAddr == PORT_A);
    strb.clrGood  = regWrEn && strb.selMain && regWrData[BIT_GOOD];
    strb.clrAbort = regWrEn && strb.selMain && regWrData[BIT_ABORT];
    strb.clrDma   = regWrEn && ((strb.selMain && regWrData[BIT_DMA]) ||
                                (strb.selPort && regWrData[PORT_CMP_BIT]));
  end
endmodule

// File: rtl/intStatData.sv
module intStatData
  import intStatPkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SUB_W        = 8,
  parameter int MODE_W       = 2,
  parameter int PORT_CMP_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrobeT        strb,
  input  logic              evtCmdStart,
  input  logic              evtCmdDone,
  input  logic              evtCmdAbort,
  input  logic              evtAtnTerm,
  input  logic              evtSeqEnd,
  input  logic [1:0]        autoModeEn,
  input  logic              evtDmaDone,
  input  logic              evtDmaStop,
  input  logic              dmaGoActive,
  input  logic [MODE_W-1:0] portMode,
  input  logic [SUB_W-1:0]  subStatA,
  input  logic [SUB_W-1:0]  subStatB,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqMainN,
  output logic              irqPortN
);
  logic goodFlag, abortFlag, dmaFlag, execFlag, aseqFlag;
  logic dmaSet, aseqSet, cmdEnd;
  logic [DATA_W-1:0] mainView, portView;

  assign dmaSet  = evtDmaDone || evtDmaStop ||
                   (dmaGoActive && (evtCmdAbort || evtAtnTerm));
  assign aseqSet = evtSeqEnd && (|autoModeEn);
  assign cmdEnd  = evtCmdDone || evtCmdAbort || evtAtnTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodFlag  <= 1'b0;
      abortFlag <= 1'b0;
      dmaFlag   <= 1'b0;
      execFlag  <= 1'b0;
      aseqFlag  <= 1'b0;
    end else begin
      goodFlag  <= evtCmdDone  || (goodFlag  && !strb.clrGood);
      abortFlag <= evtCmdAbort || (abortFlag && !strb.clrAbort);
      dmaFlag   <= dmaSet      || (dmaFlag   && !strb.clrDma);
      if (evtCmdStart)  execFlag <= 1'b1;
      else if (cmdEnd)  execFlag <= 1'b0;
      if (aseqSet)          aseqFlag <= 1'b1;
      else if (evtCmdStart) aseqFlag <= 1'b0;
    end
  end

  always_comb begin
    mainView            = '0;
    mainView[BIT_GOOD]  = goodFlag;
    mainView[BIT_ABORT] = abortFlag;
    mainView[BIT_EXEC]  = execFlag;
    mainView[BIT_SUM1]  = |subStatA;
    mainView[BIT_SUM2]  = |subStatB;
    mainView[BIT_DMA]   = dmaFlag;
    mainView[BIT_ASEQ]  = aseqFlag;
    portView               = '0;
    portView[PORT_CMP_BIT] = dmaFlag;
  end

  always_comb begin
    if (strb.selMain)      regRdData = mainView;
    else if (strb.selPort) regRdData = portView;
    else                   regRdData = '0;
  end

  assign irqMainN = !(goodFlag || abortFlag || mainView[BIT_SUM1] ||
                      mainView[BIT_SUM2] || aseqFlag);
  assign irqPortN = !(dmaFlag && (portMode != '0));

  // R2: a write-1 clear with no competing event empties the flag
  assert_clear_good_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrGood && !evtCmdDone) |=> !goodFlag);

  // R3: set wins over a same-cycle clear
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evtCmdAbort && strb.clrAbort) |=> abortFlag);

  // R4: abort while DMA-go is set terminates DMA
  assert_dma_abort_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGoActive && evtCmdAbort) |=> dmaFlag);

  // R7: start dominates a same-cycle end
  assert_exec_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    evtCmdStart |=> execFlag);

  // R8: sequence end without any auto mode never raises the flag
  assert_aseq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evtSeqEnd && autoModeEn == 2'b00 && !aseqFlag) |=> !aseqFlag);

  // R10: mode 00 keeps the port line quiet
  assert_port_route_R10: assert property (@(posedge clk) disable iff (!rstN)
    (portMode == '0) |-> irqPortN);
endmodule

// File: rtl/intStatusAgg.sv
module intStatusAgg
  import intStatPkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int SUB_W        = 8,
  parameter int MODE_W       = 2,
  parameter int MAIN_ADDR    = 'h20,
  parameter int PORT_ADDR    = 'h00,
  parameter int PORT_CMP_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evtCmdStart,
  input  logic              evtCmdDone,
  input  logic              evtCmdAbort,
  input  logic              evtAtnTerm,
  input  logic              evtSeqEnd,
  input  logic [1:0]        autoModeEn,
  input  logic              evtDmaDone,
  input  logic              evtDmaStop,
  input  logic              dmaGoActive,
  input  logic [MODE_W-1:0] portMode,
  input  logic [SUB_W-1:0]  subStatA,
  input  logic [SUB_W-1:0]  subStatB,
  output logic              irqMainN,
  output logic              irqPortN
);
  statStrobeT strb;

  intStatCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_ADDR(MAIN_ADDR),
    .PORT_ADDR(PORT_ADDR), .PORT_CMP_BIT(PORT_CMP_BIT)
  ) i_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .strb(strb)
  );

  intStatData #(
    .DATA_W(DATA_W), .SUB_W(SUB_W), .MODE_W(MODE_W), .PORT_CMP_BIT(PORT_CMP_BIT)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .evtCmdStart(evtCmdStart), .evtCmdDone(evtCmdDone),
    .evtCmdAbort(evtCmdAbort), .evtAtnTerm(evtAtnTerm),
    .evtSeqEnd(evtSeqEnd), .autoModeEn(autoModeEn),
    .evtDmaDone(evtDmaDone), .evtDmaStop(evtDmaStop),
    .dmaGoActive(dmaGoActive), .portMode(portMode),
    .subStatA(subStatA), .subStatB(subStatB),
    .regRdData(regRdData), .irqMainN(irqMainN), .irqPortN(irqPortN)
  );
endmodule

// File: tb/test_intStatusAgg.sv
module test_intStatusAgg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = 8'h20;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic evtCmdStart = 0, evtCmdDone = 0, evtCmdAbort = 0, evtAtnTerm = 0;
  logic evtSeqEnd = 0, evtDmaDone = 0, evtDmaStop = 0, dmaGoActive = 0;
  logic [1:0] autoModeEn = 2'b00;
  logic [1:0] portMode = 2'b00;
  logic [7:0] subStatA = 8'h00, subStatB = 8'h00;
  logic irqMainN, irqPortN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intStatusAgg i_intStatusAgg (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .evtCmdStart(evtCmdStart), .evtCmdDone(evtCmdDone),
    .evtCmdAbort(evtCmdAbort), .evtAtnTerm(evtAtnTerm),
    .evtSeqEnd(evtSeqEnd), .autoModeEn(autoModeEn),
    .evtDmaDone(evtDmaDone), .evtDmaStop(evtDmaStop),
    .dmaGoActive(dmaGoActive), .portMode(portMode),
    .subStatA(subStatA), .subStatB(subStatB),
    .irqMainN(irqMainN), .irqPortN(irqPortN)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 8'h00; regAddr = 8'h20;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearAll();
    wr(8'h20, 8'hFF);
  endtask

  task automatic testReset();
    logic [7:0] d;
    rd(8'h20, d); chk("R1 main reg", d, 8'h00);
    rd(8'h00, d); chk("R1 port reg", d, 8'h00);
    chk("R1 irqMainN", {7'd0, irqMainN}, 8'h01);
    chk("R1 irqPortN", {7'd0, irqPortN}, 8'h01);
  endtask

  task automatic testSticky();
    logic [7:0] d;
    @(negedge clk); evtCmdDone = 1; @(negedge clk); evtCmdDone = 0;
    rd(8'h20, d); chk("R2 good set", d, 8'h80);
    chk("R9 irqMainN by good", {7'd0, irqMainN}, 8'h00);
    wr(8'h20, 8'h00); rd(8'h20, d); chk("R2 write 0 keeps", d, 8'h80);
    wr(8'h20, 8'h80); rd(8'h20, d); chk("R2 write 1 clears good", d, 8'h00);
    @(negedge clk); evtCmdAbort = 1; @(negedge clk); evtCmdAbort = 0;
    rd(8'h20, d); chk("R2 abort set", d, 8'h40);
    wr(8'h20, 8'h40); rd(8'h20, d); chk("R2 abort cleared", d, 8'h00);
    chk("R9 irqMainN released", {7'd0, irqMainN}, 8'h01);
  endtask

  task automatic testSetWins();
    logic [7:0] d;
    @(negedge clk); evtCmdDone = 1; @(negedge clk); evtCmdDone = 0;
    @(negedge clk);
    regAddr = 8'h20; regWrData = 8'h80; regWrEn = 1; evtCmdDone = 1;
    @(negedge clk);
    regWrEn = 0; evtCmdDone = 0;
    rd(8'h20, d); chk("R3 good set beats clear", d, 8'h80);
    @(negedge clk); evtDmaDone = 1; @(negedge clk); evtDmaDone = 0;
    @(negedge clk);
    regAddr = 8'h00; regWrData = 8'h01; regWrEn = 1; evtDmaDone = 1;
    @(negedge clk);
    regWrEn = 0; evtDmaDone = 0;
    rd(8'h20, d); chk("R3 dma set beats clear", d, 8'h82);
    clearAll();
  endtask

  task automatic testDmaCauses();
    logic [7:0] d;
    @(negedge clk); evtDmaDone = 1; @(negedge clk); evtDmaDone = 0;
    rd(8'h20, d); chk("R4 dma done", d, 8'h02);
    rd(8'h00, d); chk("R5 mirror shows", d, 8'h01);
    wr(8'h00, 8'h01);
    rd(8'h20, d); chk("R5 clear via 0x00", d, 8'h00);
    @(negedge clk); evtDmaStop = 1; @(negedge clk); evtDmaStop = 0;
    rd(8'h20, d); chk("R4 dma stop", d, 8'h02);
    wr(8'h20, 8'h02);
    rd(8'h00, d); chk("R5 clear via 0x20", d, 8'h00);
    @(negedge clk); evtAtnTerm = 1; @(negedge clk); evtAtnTerm = 0;
    rd(8'h20, d); chk("R4 atn without go", d, 8'h00);
    @(negedge clk); evtCmdAbort = 1; @(negedge clk); evtCmdAbort = 0;
    rd(8'h20, d); chk("R4 abort without go", d, 8'h40);
    clearAll();
    dmaGoActive = 1;
    @(negedge clk); evtAtnTerm = 1; @(negedge clk); evtAtnTerm = 0;
    rd(8'h20, d); chk("R4 atn with go", d, 8'h02);
    clearAll();
    @(negedge clk); evtCmdAbort = 1; @(negedge clk); evtCmdAbort = 0;
    rd(8'h20, d); chk("R4 abort with go", d, 8'h42);
    dmaGoActive = 0;
    clearAll();
  endtask

  task automatic testRouting();
    logic [7:0] d;
    @(negedge clk); evtDmaDone = 1; @(negedge clk); evtDmaDone = 0;
    portMode = 2'b00; #1;
    chk("R10 mode00 port quiet", {7'd0, irqPortN}, 8'h01);
    chk("R9 dma not on main mode00", {7'd0, irqMainN}, 8'h01);
    portMode = 2'b10; #1;
    chk("R10 mode10 port low", {7'd0, irqPortN}, 8'h00);
    chk("R9 dma not on main mode10", {7'd0, irqMainN}, 8'h01);
    wr(8'h20, 8'h02); #1;
    chk("R10 port released", {7'd0, irqPortN}, 8'h01);
    portMode = 2'b00;
    rd(8'h20, d); chk("R10 flag gone", d, 8'h00);
  endtask

  task automatic testSummary();
    logic [7:0] d;
    subStatA = 8'h10;
    rd(8'h20, d); chk("R6 sum1 high", d, 8'h10);
    chk("R9 main by sum1", {7'd0, irqMainN}, 8'h00);
    wr(8'h20, 8'h18); rd(8'h20, d); chk("R6 sum1 write ignored", d, 8'h10);
    subStatA = 8'h00; subStatB = 8'h81;
    rd(8'h20, d); chk("R6 sum2 high", d, 8'h08);
    subStatB = 8'h00;
    rd(8'h20, d); chk("R6 both low", d, 8'h00);
    chk("R9 main released", {7'd0, irqMainN}, 8'h01);
  endtask

  task automatic testExec();
    logic [7:0] d;
    @(negedge clk); evtCmdStart = 1; @(negedge clk); evtCmdStart = 0;
    rd(8'h20, d); chk("R7 exec set", d, 8'h20);
    chk("R7 exec no main irq", {7'd0, irqMainN}, 8'h01);
    chk("R7 exec no port irq", {7'd0, irqPortN}, 8'h01);
    wr(8'h20, 8'h20); rd(8'h20, d); chk("R7 write ignored", d, 8'h20);
    @(negedge clk); evtAtnTerm = 1; @(negedge clk); evtAtnTerm = 0;
    rd(8'h20, d); chk("R7 atn ends exec", d, 8'h00);
    @(negedge clk); evtCmdStart = 1; evtCmdDone = 1;
    @(negedge clk); evtCmdStart = 0; evtCmdDone = 0;
    rd(8'h20, d); chk("R7 start wins", d, 8'hA0);
    @(negedge clk); evtCmdDone = 1; @(negedge clk); evtCmdDone = 0;
    rd(8'h20, d); chk("R7 done ends exec", d, 8'h80);
    clearAll();
  endtask

  task automatic testAutoSeq();
    logic [7:0] d;
    autoModeEn = 2'b00;
    @(negedge clk); evtSeqEnd = 1; @(negedge clk); evtSeqEnd = 0;
    rd(8'h20, d); chk("R8 no auto mode", d, 8'h00);
    autoModeEn = 2'b10;
    @(negedge clk); evtSeqEnd = 1; @(negedge clk); evtSeqEnd = 0;
    rd(8'h20, d); chk("R8 auto2 sets", d, 8'h01);
    chk("R9 main by aseq", {7'd0, irqMainN}, 8'h00);
    wr(8'h20, 8'h01); rd(8'h20, d); chk("R8 write ignored", d, 8'h01);
    @(negedge clk); evtCmdStart = 1; @(negedge clk); evtCmdStart = 0;
    rd(8'h20, d); chk("R8 start clears", d, 8'h20);
    autoModeEn = 2'b01;
    @(negedge clk); evtSeqEnd = 1; @(negedge clk); evtSeqEnd = 0;
    rd(8'h20, d); chk("R8 auto1 sets", d, 8'h21);
    @(negedge clk); evtCmdAbort = 1; @(negedge clk); evtCmdAbort = 0;
    autoModeEn = 2'b00;
    clearAll();
    @(negedge clk); evtCmdStart = 1; @(negedge clk); evtCmdStart = 0;
    @(negedge clk); evtCmdDone = 1; @(negedge clk); evtCmdDone = 0;
    clearAll();
  endtask

  task automatic testReserved();
    logic [7:0] d;
    wr(8'h20, 8'h04); rd(8'h20, d); chk("R11 bit2 zero", d, 8'h00);
    subStatA = 8'hFF; subStatB = 8'hFF;
    @(negedge clk); evtCmdDone = 1; evtDmaDone = 1;
    @(negedge clk); evtCmdDone = 0; evtDmaDone = 0;
    rd(8'h20, d); chk("R11 bit2 zero all set", d & 8'h04, 8'h00);
    rd(8'h00, d); chk("R11 port unused bits", d, 8'h01);
    rd(8'h44, d); chk("R11 other addr", d, 8'h00);
    subStatA = 8'h00; subStatB = 8'h00;
    clearAll();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        testReset();
        rstN = 1'b1;
        tick();
        testReset();
        testSticky();
        testSetWins();
        testDmaCauses();
        testRouting();
        testSummary();
        testExec();
        testAutoSeq();
        testReserved();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual=hung expected=finished");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule